// File: doc/BRIEF.md
# Bank-Aware Dirty Victim Selector

This block works next to the replacement logic of a set-associative last-level cache. On each request it chooses the way to evict from one set. It can also name a dirty way that should be written back early and then marked clean. Its choice depends on how costly the DRAM write of each dirty candidate would be, not only on recency. The cost depends on which DRAM banks already have writes waiting in the memory controller's write queue. The selector keeps one pending bit per DRAM bank. The controller sets a bank's bit when it queues a write to that bank and clears it when the write retires.

For each way, the caller presents a valid bit, a dirty bit, a recency rank and the 6-bit DRAM bank the line maps to. Three operating modes are available. The eviction mode substitutes a cheap dirty line for an expensive dirty victim. The cleansing mode keeps the recency victim and asks for a separate early write-back of a cheap dirty line. The hybrid mode picks one of these two actions for each decision, using a small saturating counter. The cache raises one counter input when a miss was caused by an early eviction, and the other when a cleansed line became dirty again before it was evicted.

Top module: `bank_victim_sel`

## Requirements
- R1: A request strobe on cycle n gives `sel_valid` high on cycle n+1 only. `cln_valid` is never high without `sel_valid`.
- R2: If any presented way is invalid, the victim is the lowest-numbered invalid way, in every mode.
- R3: Write cost of a way:
  - A clean way has no cost.
  - A dirty way has weight 24 if its own bank has a pending write.
  - Otherwise a dirty way has weight 6 if another bank of its group has a pending write.
  - Otherwise a dirty way has weight 1.
  - The bank field is 6 bits. Bits [5:2] give the group (16 groups of 4 banks, 64 pending bits in total).
- R4: A queued write sets its bank's pending bit on the next cycle, and a retire clears it. If a queue and a retire name the same bank in one cycle, the bit ends up set.
- R5: Eviction mode when every way is valid:
  - The default victim is the way with the highest rank (rank WAYS-1 is least recent).
  - If that way is dirty, the victim becomes the oldest weight-1 dirty way among the ways ranked WAYS-4 or above, when such a way exists.
- R6: A clean least-recent way is never replaced by a dirty substitute.
- R7: Cleansing mode:
  - The victim is the same as with recency alone (invalid way first, else highest rank).
  - `cln_valid` is raised with the oldest weight-1 dirty way among the four oldest ranks, excluding the victim.
  - If no such way exists, `cln_valid` stays low.
- R8: Eviction mode never raises `cln_valid`.
- R9: The hybrid counter is 4 bits wide and resets to 0. It counts up on `early_evict_miss` and down on `cleansed_redirty`, and stays put when both are high. It saturates at 15 and at 0.
- R10: In hybrid mode, a counter value below 8 gives the eviction action. A value of 8 or more gives the cleansing action.
- R11: Mode encoding is 0 for eviction and 1 for cleansing. Both 2 and 3 select hybrid.
- R12: Among equal ranks the lowest way index wins, both for the default victim and for a substitute or cleanse candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Operating mode (R11) |
| req | input | 1 | Selection request strobe |
| way_valid | input | WAYS | Valid bit per way |
| way_dirty | input | WAYS | Dirty bit per way |
| way_rank | input | WAYS*RANK_W | Recency rank per way, higher is older |
| way_bank | input | WAYS*BANK_W | DRAM bank per way, group in upper bits |
| wr_enq | input | 1 | A write was queued |
| wr_enq_bank | input | BANK_W | Bank of the queued write |
| wr_done | input | 1 | A queued write retired |
| wr_done_bank | input | BANK_W | Bank of the retired write |
| early_evict_miss | input | 1 | Miss caused by an early eviction |
| cleansed_redirty | input | 1 | Cleansed line written again before eviction |
| sel_valid | output | 1 | Result valid |
| sel_victim | output | WAY_W | Way to evict |
| cln_valid | output | 1 | Early write-back requested |
| cln_way | output | WAY_W | Way to write back and mark clean |

## Verification
The bench sets a dirty least-recent way against a cheap substitute and moves its bank through all three cost classes. A design that ignored the bank-group neighbour, or that let a retire win over a simultaneous queue, would keep the wrong victim. It walks the hybrid counter across the 7/8 boundary and past both saturation points. A counter that wrapped or ignored simultaneous pulses would flip between actions at the wrong step. Large sweeps then cover all four mode codes, with invalid ways and duplicate ranks mixed in. These catch a design that displaces a clean least-recent way, names the victim as its own cleanse target, or breaks ties toward the higher index.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
    typedef enum logic [1:0] {
        MODE_EVICT   = 2'd0,
        MODE_CLEANSE = 2'd1,
        MODE_HYB     = 2'd2,
        MODE_HYB_ALT = 2'd3
    } sel_mode_e;

    typedef enum logic [1:0] {
        COST_NONE = 2'd0,
        COST_LOW  = 2'd1,
        COST_MID  = 2'd2,
        COST_HIGH = 2'd3
    } wr_cost_e;
endpackage

// File: rtl/vsel_pending.sv
module vsel_pending #(
    parameter int NBANK  = 64,
    parameter int BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_vld,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic              done_vld,
    input  logic [BANK_W-1:0] done_bank,
    output logic [NBANK-1:0]  pend
);
    logic [NBANK-1:0] pend_d, pend_q;

    // retire applied first so a same-cycle queue to that bank leaves it set (R4)
    always_comb begin
        pend_d = pend_q;
        if (done_vld) pend_d[done_bank] = 1'b0;
        if (enq_vld)  pend_d[enq_bank]  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
endmodule

// File: rtl/vsel_way_cost.sv
module vsel_way_cost
    import vsel_pkg::*;
#(
    parameter int NGRP   = 16,
    parameter int BPG    = 4,
    parameter int BANK_W = $clog2(NGRP*BPG)
) (
    input  logic                dirty,
    input  logic [BANK_W-1:0]   bank,
    input  logic [NGRP*BPG-1:0] pend,
    output wr_cost_e            cost
);
    localparam int BSEL_W = $clog2(BPG);
    localparam int GRP_W  = BANK_W - BSEL_W;

    logic [NGRP-1:0]  grp_any;
    logic [GRP_W-1:0] grp;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_any[g] = |pend[g*BPG +: BPG];
    end

    assign grp = bank[BANK_W-1:BSEL_W];

    always_comb begin
        if (!dirty)            cost = COST_NONE;
        else if (pend[bank])   cost = COST_HIGH;
        else if (grp_any[grp]) cost = COST_MID;
        else                   cost = COST_LOW;
    end
endmodule

// File: rtl/vsel_hyb_ctr.sv
module vsel_hyb_ctr #(
    parameter int CTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CTR_W-1:0] ctr
);
    logic [CTR_W-1:0] ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (inc && !dec && ctr_q != '1)      ctr_d = ctr_q + 1'b1;
        else if (dec && !inc && ctr_q != '0) ctr_d = ctr_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign ctr = ctr_q;
endmodule

// File: rtl/bank_victim_sel.sv
module bank_victim_sel
    import vsel_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int RANK_W = 3,
    parameter int NGRP   = 16,
    parameter int BPG    = 4,
    parameter int SUBST  = 4,
    parameter int CTR_W  = 4,
    localparam int NBANK  = NGRP * BPG,
    localparam int BANK_W = $clog2(NBANK),
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode,
    input  logic                     req,
    input  logic [WAYS-1:0]          way_valid,
    input  logic [WAYS-1:0]          way_dirty,
    input  logic [WAYS*RANK_W-1:0]   way_rank,
    input  logic [WAYS*BANK_W-1:0]   way_bank,
    input  logic                     wr_enq,
    input  logic [BANK_W-1:0]        wr_enq_bank,
    input  logic                     wr_done,
    input  logic [BANK_W-1:0]        wr_done_bank,
    input  logic                     early_evict_miss,
    input  logic                     cleansed_redirty,
    output logic                     sel_valid,
    output logic [WAY_W-1:0]         sel_victim,
    output logic                     cln_valid,
    output logic [WAY_W-1:0]         cln_way
);
    localparam int SUB_FLOOR = WAYS - SUBST;

    typedef struct packed {
        logic             vld;
        logic [WAY_W-1:0] victim;
        logic             cln_vld;
        logic [WAY_W-1:0] cln;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [NBANK-1:0]  pend_vec;
    logic [CTR_W-1:0]  hyb_ctr;
    logic [RANK_W-1:0] rank_a [WAYS];
    wr_cost_e          cost_a [WAYS];

    vsel_pending #(.NBANK(NBANK), .BANK_W(BANK_W)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .enq_vld(wr_enq), .enq_bank(wr_enq_bank),
        .done_vld(wr_done), .done_bank(wr_done_bank),
        .pend(pend_vec)
    );

    vsel_hyb_ctr #(.CTR_W(CTR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .inc(early_evict_miss), .dec(cleansed_redirty),
        .ctr(hyb_ctr)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign rank_a[w] = way_rank[w*RANK_W +: RANK_W];
        vsel_way_cost #(.NGRP(NGRP), .BPG(BPG), .BANK_W(BANK_W)) u_cost (
            .dirty(way_dirty[w]),
            .bank(way_bank[w*BANK_W +: BANK_W]),
            .pend(pend_vec),
            .cost(cost_a[w])
        );
    end

    logic             inv_any, sub_found, cln_found, use_cln;
    logic [WAY_W-1:0] inv_idx, lru_idx, base_idx, sub_idx, cln_idx, ev_idx;

    // candidate search: invalid first, oldest rank, cheap substitutes (R2, R5, R7, R12)
    always_comb begin
        inv_any = 1'b0;
        inv_idx = '0;
        for (int w = WAYS-1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                inv_any = 1'b1;
                inv_idx = WAY_W'(w);
            end
        end

        lru_idx = '0;
        for (int w = 1; w < WAYS; w++) begin
            if (rank_a[w] > rank_a[lru_idx]) lru_idx = WAY_W'(w);
        end
        base_idx = inv_any ? inv_idx : lru_idx;

        sub_found = 1'b0;
        sub_idx   = '0;
        cln_found = 1'b0;
        cln_idx   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_valid[w] && cost_a[w] == COST_LOW && int'(rank_a[w]) >= SUB_FLOOR) begin
                if (!sub_found || rank_a[w] > rank_a[sub_idx]) begin
                    sub_found = 1'b1;
                    sub_idx   = WAY_W'(w);
                end
                if (WAY_W'(w) != base_idx && (!cln_found || rank_a[w] > rank_a[cln_idx])) begin
                    cln_found = 1'b1;
                    cln_idx   = WAY_W'(w);
                end
            end
        end

        if (inv_any)                             ev_idx = inv_idx;
        else if (way_dirty[lru_idx] && sub_found) ev_idx = sub_idx;
        else                                     ev_idx = lru_idx;

        use_cln = (mode == MODE_CLEANSE) || (mode[1] && hyb_ctr[CTR_W-1]);
    end

    always_comb begin
        st_d         = st_q;
        st_d.vld     = req;
        st_d.cln_vld = 1'b0;
        if (req) begin
            st_d.victim  = use_cln ? base_idx : ev_idx;
            st_d.cln_vld = use_cln && cln_found;
            st_d.cln     = cln_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_valid  = st_q.vld;
    assign sel_victim = st_q.victim;
    assign cln_valid  = st_q.cln_vld;
    assign cln_way    = st_q.cln;
endmodule

// File: rtl/vsel_checker.sv
module vsel_checker #(
    parameter int WAYS   = 8,
    parameter int BANK_W = 6,
    parameter int NBANK  = 64,
    parameter int CTR_W  = 4,
    parameter int WAY_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              req,
    input logic [WAYS-1:0]   way_valid,
    input logic              wr_enq,
    input logic [BANK_W-1:0] wr_enq_bank,
    input logic              wr_done,
    input logic [BANK_W-1:0] wr_done_bank,
    input logic              inc,
    input logic              dec,
    input logic [NBANK-1:0]  pend,
    input logic [CTR_W-1:0]  ctr,
    input logic              sel_valid,
    input logic [WAY_W-1:0]  sel_victim,
    input logic              cln_valid,
    input logic [WAY_W-1:0]  cln_way
);
    logic [WAYS-1:0] valid_at_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   valid_at_req <= '1;
        else if (req) valid_at_req <= way_valid;
    end

    a_r1_result_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> sel_valid);
    a_r1_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !sel_valid);
    a_r1_cleanse_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
        cln_valid |-> sel_valid);
    a_r2_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !(&valid_at_req)) |-> !valid_at_req[sel_victim]);
    a_r7_cleanse_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
        cln_valid |-> (cln_way != sel_victim));
    a_r8_evict_no_cleanse: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 2'd0) |=> !cln_valid);
    a_r4_enq_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enq |=> pend[$past(wr_enq_bank)]);
    a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && !(wr_enq && wr_enq_bank == wr_done_bank)) |=> !pend[$past(wr_done_bank)]);
    a_r9_top_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr == '1 && inc && !dec) |=> ctr == '1);
    a_r9_floor_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr == '0 && dec && !inc) |=> ctr == '0);
    a_r9_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctr) |-> (ctr == CTR_W'($past(ctr) + 1'b1) || ctr == CTR_W'($past(ctr) - 1'b1)));
endmodule

bind bank_victim_sel vsel_checker #(
    .WAYS(WAYS), .BANK_W(BANK_W), .NBANK(NBANK), .CTR_W(CTR_W), .WAY_W(WAY_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .req(req), .way_valid(way_valid),
    .wr_enq(wr_enq), .wr_enq_bank(wr_enq_bank),
    .wr_done(wr_done), .wr_done_bank(wr_done_bank),
    .inc(early_evict_miss), .dec(cleansed_redirty),
    .pend(pend_vec), .ctr(hyb_ctr),
    .sel_valid(sel_valid), .sel_victim(sel_victim),
    .cln_valid(cln_valid), .cln_way(cln_way)
);

// File: tb/bank_victim_sel_test.sv
`timescale 1ns/100ps
module bank_victim_sel_test;
    localparam int WAYS = 8;
    localparam int RW   = 3;
    localparam int BW   = 6;
    localparam int WW   = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n;
    logic [1:0]       mode;
    logic             req;
    logic [WAYS-1:0]  way_valid, way_dirty;
    logic [WAYS*RW-1:0] way_rank;
    logic [WAYS*BW-1:0] way_bank;
    logic             wr_enq, wr_done, early_evict_miss, cleansed_redirty;
    logic [BW-1:0]    wr_enq_bank, wr_done_bank;
    logic             sel_valid, cln_valid;
    logic [WW-1:0]    sel_victim, cln_way;

    bank_victim_sel uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .req(req),
        .way_valid(way_valid), .way_dirty(way_dirty),
        .way_rank(way_rank), .way_bank(way_bank),
        .wr_enq(wr_enq), .wr_enq_bank(wr_enq_bank),
        .wr_done(wr_done), .wr_done_bank(wr_done_bank),
        .early_evict_miss(early_evict_miss), .cleansed_redirty(cleansed_redirty),
        .sel_valid(sel_valid), .sel_victim(sel_victim),
        .cln_valid(cln_valid), .cln_way(cln_way)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    bit [63:0] pm = '0;
    int cm = 0;
    int rk [WAYS];
    int bk [WAYS];
    bit vv [WAYS];
    bit dd [WAYS];

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R3: 0 clean, 24 own bank pending, 6 group pending, 1 otherwise
    function automatic int wcost(int w);
        int g;
        if (!dd[w]) return 0;
        if (pm[bk[w]]) return 24;
        g = bk[w] / 4;
        for (int i = 0; i < 4; i++) if (pm[g*4 + i]) return 6;
        return 1;
    endfunction

    task automatic expect_sel(int md, output int ev, output int cv, output int cw);
        int inv, lru, base, sub, cl, evv;
        bit usec;
        inv = -1;
        for (int w = 0; w < WAYS; w++) if (!vv[w] && inv < 0) inv = w;
        lru = 0;
        for (int w = 1; w < WAYS; w++) if (rk[w] > rk[lru]) lru = w;
        base = (inv >= 0) ? inv : lru;
        sub = -1;
        cl  = -1;
        for (int w = 0; w < WAYS; w++) begin
            if (vv[w] && wcost(w) == 1 && rk[w] >= WAYS - 4) begin
                if (sub < 0 || rk[w] > rk[sub]) sub = w;
                if (w != base && (cl < 0 || rk[w] > rk[cl])) cl = w;
            end
        end
        evv  = (inv >= 0) ? inv : ((dd[lru] && sub >= 0) ? sub : lru);
        usec = (md == 1) || (md >= 2 && cm >= 8);
        ev = usec ? base : evv;
        cv = (usec && cl >= 0) ? 1 : 0;
        cw = (cl >= 0) ? cl : 0;
    endtask

    task automatic run_req(int md, string tag);
        int ev, cv, cw;
        for (int w = 0; w < WAYS; w++) begin
            way_valid[w] = vv[w];
            way_dirty[w] = dd[w];
            way_rank[w*RW +: RW] = RW'(rk[w]);
            way_bank[w*BW +: BW] = BW'(bk[w]);
        end
        mode = 2'(md);
        req  = 1'b1;
        @(negedge clk);
        req = 1'b0;
        expect_sel(md, ev, cv, cw);
        check("R1 result valid", int'(sel_valid), 1);
        check({tag, " victim"}, int'(sel_victim), ev);
        check({tag, " cleanse flag"}, int'(cln_valid), cv);
        if (cv != 0) check({tag, " cleanse way"}, int'(cln_way), cw);
        @(negedge clk);
        check("R1 single cycle", int'(sel_valid), 0);
    endtask

    task automatic pend_op(bit e, int eb, bit d, int db);
        wr_enq = e; wr_enq_bank = BW'(eb);
        wr_done = d; wr_done_bank = BW'(db);
        @(negedge clk);
        wr_enq = 1'b0; wr_done = 1'b0;
        if (d) pm[db] = 1'b0;
        if (e) pm[eb] = 1'b1;
    endtask

    task automatic ctr_op(bit i, bit d);
        early_evict_miss = i; cleansed_redirty = d;
        @(negedge clk);
        early_evict_miss = 1'b0; cleansed_redirty = 1'b0;
        if (i && !d && cm < 15) cm++;
        else if (d && !i && cm > 0) cm--;
    endtask

    task automatic base_set();
        for (int w = 0; w < WAYS; w++) begin
            vv[w] = 1'b1; dd[w] = 1'b0; rk[w] = w; bk[w] = 32 + w;
        end
    endtask

    task automatic rand_set(bit dup);
        int j, t;
        for (int w = 0; w < WAYS; w++) begin
            vv[w] = ($urandom % 100) >= 8;
            dd[w] = ($urandom % 3) != 0;
            bk[w] = int'($urandom % 16);
            rk[w] = w;
        end
        for (int i = WAYS-1; i > 0; i--) begin
            j = int'($urandom_range(i, 0));
            t = rk[i]; rk[i] = rk[j]; rk[j] = t;
        end
        if (dup) for (int w = 0; w < WAYS; w++) rk[w] = int'($urandom % 8);
    endtask

    initial begin
        rst_n = 1'b0; req = 1'b0; mode = 2'd0;
        way_valid = '0; way_dirty = '0; way_rank = '0; way_bank = '0;
        wr_enq = 1'b0; wr_done = 1'b0; wr_enq_bank = '0; wr_done_bank = '0;
        early_evict_miss = 1'b0; cleansed_redirty = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 reset result", int'(sel_valid), 0);
        check("R1 reset cleanse", int'(cln_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4: LRU way 7 dirty on bank 0, way 6 cheap dirty in group 2
        base_set();
        dd[7] = 1'b1; bk[7] = 0;
        dd[6] = 1'b1; bk[6] = 8;
        run_req(0, "R3 weight1 LRU kept");
        pend_op(1, 0, 0, 0);
        run_req(0, "R3 own bank pending");
        pend_op(1, 1, 1, 0);
        run_req(0, "R3 group pending");
        pend_op(0, 0, 1, 1);
        run_req(0, "R4 retire clears");
        pend_op(1, 0, 1, 0);
        run_req(0, "R4 set wins");
        run_req(1, "R7 cleanse beside LRU");
        // R6: clean LRU stays the victim
        dd[7] = 1'b0;
        run_req(0, "R6 clean LRU kept");
        dd[7] = 1'b1;
        // R2: invalid way wins in every mode
        vv[3] = 1'b0; vv[5] = 1'b0;
        run_req(0, "R2 invalid evict");
        run_req(1, "R2 invalid cleanse");
        vv[3] = 1'b1; vv[5] = 1'b1;
        // R12: equal ranks pick lowest index
        rk[2] = 7; rk[7] = 7;
        run_req(0, "R12 rank tie");
        rk[2] = 2;
        // R9/R10: walk hybrid counter past both ends
        for (int k = 0; k < 18; k++) begin
            ctr_op(1, 0);
            run_req(2, "R10 hybrid up");
        end
        ctr_op(1, 1);
        run_req(3, "R9 both pulses hold");
        for (int k = 0; k < 18; k++) begin
            ctr_op(0, 1);
            run_req(3, "R10 hybrid down");
        end
        ctr_op(1, 1);
        run_req(2, "R9 floor hold");
        // R11/R5/R7/R12 sweeps over all mode codes
        for (int md = 0; md < 4; md++) begin
            for (int n = 0; n < 400; n++) begin
                if (n % 50 == 0) ctr_op(md == 3, md == 2);
                if (($urandom % 10) < 4) pend_op(1, int'($urandom % 16), 0, 0);
                pend_op(0, 0, 1, int'($urandom % 16));
                pend_op(0, 0, 1, int'($urandom % 16));
                rand_set(n % 4 == 3);
                run_req(md, "R11 sweep R5 R7 R12");
            end
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule